// File: doc/BRIEF.md
# DMA Channel Control/Status Register File

This block is the software-visible register file of one descriptor-driven DMA/XOR channel. A simple 32-bit read/write bus reaches four registers: a control word, a status word, a read-only copy of the descriptor address the engine is working on, and a writable link address for the next descriptor. Software writes to the control word become a level enable and a one-cycle append (resume) strobe for the channel engine. The engine reports completion, errors and descriptor fetches through plain event inputs.

Completion and error events are held in sticky status bits. Software clears them by writing 1 to their positions. A completion event is recorded only when the descriptor that raised it had its interrupt-enable flag set; that flag is captured on each descriptor fetch. The interrupt line is high while any sticky bit is set. Read data is registered and appears one cycle after the read request. It holds its value until the next request.

Top module: `xfer_chan_csr`

## Requirements
- R1: After reset, chanEnable, appendPulse and irq are 0, and busRdData, nextDescAddr, the current descriptor register and every sticky status bit are 0.
- R2: Offset 0x00 is the control word. Bit 0 is a read/write enable that drives chanEnable in the cycle after the write. Every other bit reads 0.
- R3: A write to offset 0x00 with bit 1 set drives appendPulse high for exactly the next cycle. Bit 1 always reads back 0.
- R4: Offset 0x24 holds a read/write 32-bit next-descriptor address, presented on nextDescAddr.
- R5: Offset 0x08 is the current descriptor address. It is loaded from engFetchAddr when engFetch is high. Bus writes to it have no effect.
- R6: Status (offset 0x04) bit 13 reads as the live value of engBusy.
- R7: Status bit 12 (end of transfer, engEot) and bit 11 (end of chain, engEoc) become set and stay set only when the last fetched descriptor had its interrupt-enable flag (engFetchIrqEn) at 1. A fetch in the same cycle as the event takes effect afterwards.
- R8: Status error bits are sticky and set unconditionally: bit 9 internal parity, bit 5 memory controller abort, bit 4 target abort, bit 3 master abort.
- R9: Writing 1 to a sticky status bit clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as the clear wins.
- R10: irq is high exactly while at least one of status bits 12, 11, 9, 5, 4, 3 is set.
- R11: Read data is returned on busRdData one cycle after busRdEn and held otherwise. Undefined offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write request |
| busRdEn | input | 1 | Register read request |
| busAddr | input | 8 | Byte offset of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| engBusy | input | 1 | Engine busy level |
| engFetch | input | 1 | Engine fetched a descriptor this cycle |
| engFetchAddr | input | 32 | Address of the fetched descriptor |
| engFetchIrqEn | input | 1 | Interrupt-enable flag of the fetched descriptor |
| engEot | input | 1 | End-of-transfer event |
| engEoc | input | 1 | End-of-chain event |
| engErrParity | input | 1 | Internal parity error event |
| engErrMcAbort | input | 1 | Memory controller abort event |
| engErrTgtAbort | input | 1 | Target abort event |
| engErrMstAbort | input | 1 | Master abort event |
| chanEnable | output | 1 | Channel enable level |
| appendPulse | output | 1 | One-cycle append/resume strobe |
| nextDescAddr | output | 32 | Next descriptor address |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences come first:
- enable and append writes;
- fetches with the interrupt-enable flag set and then cleared, which tells gated completion events apart from ungated errors;
- partial write-one-to-clear masks, which show that cleared bits differ from untouched ones;
- an event that coincides with its own clear, which exposes the priority.

After that, a long seeded random mix issues reads and writes to defined and undefined offsets together with random engine events and fetches. A reference model checks every output and every read each cycle. This catches interactions that the directed cases miss, such as a write that lands in the same cycle as an event or a fetch.

// File: rtl/xfer_csr_pkg.sv
`timescale 1ns/1ps
package xfer_csr_pkg;
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_CUR  = 'h08;
  localparam int OFS_NEXT = 'h24;

  localparam int BIT_ENABLE = 0;
  localparam int BIT_APPEND = 1;
  localparam int BIT_BUSY   = 13;

  // Sticky status events: index 0..5 -> bit position
  localparam int NUM_STICKY = 6;
  localparam int STICKY_POS [NUM_STICKY] = '{12, 11, 9, 5, 4, 3};

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_CUR, SEL_NEXT
  } rdSelT;

  typedef struct packed {
    logic  wrCtrl;
    logic  wrStat;
    logic  wrNext;
    logic  rdStb;
    rdSelT rdSel;
  } csrStrobeT;
endpackage

// File: rtl/xfer_csr_decode.sv
`timescale 1ns/1ps
module xfer_csr_decode
  import xfer_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output csrStrobeT         strb
);
  logic isCtrl, isStat, isCur, isNext;

  always_comb begin
    isCtrl = (busAddr == ADDR_W'(OFS_CTRL));
    isStat = (busAddr == ADDR_W'(OFS_STAT));
    isCur  = (busAddr == ADDR_W'(OFS_CUR));
    isNext = (busAddr == ADDR_W'(OFS_NEXT));

    strb.wrCtrl = busWrEn & isCtrl;
    strb.wrStat = busWrEn & isStat;
    strb.wrNext = busWrEn & isNext;
    strb.rdStb  = busRdEn;
    if (isCtrl)      strb.rdSel = SEL_CTRL;
    else if (isStat) strb.rdSel = SEL_STAT;
    else if (isCur)  strb.rdSel = SEL_CUR;
    else if (isNext) strb.rdSel = SEL_NEXT;
    else             strb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/xfer_csr_regs.sv
`timescale 1ns/1ps
module xfer_csr_regs
  import xfer_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobeT         strb,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              engBusy,
  input  logic              engFetch,
  input  logic [DATA_W-1:0] engFetchAddr,
  input  logic              engFetchIrqEn,
  input  logic              engEot,
  input  logic              engEoc,
  input  logic              engErrParity,
  input  logic              engErrMcAbort,
  input  logic              engErrTgtAbort,
  input  logic              engErrMstAbort,
  output logic              chanEnable,
  output logic              appendPulse,
  output logic [DATA_W-1:0] nextDescAddr,
  output logic [DATA_W-1:0] curDescAddr,
  output logic [DATA_W-1:0] statusWord,
  output logic              irq
);
  logic                  enableQ;
  logic                  appendQ;
  logic                  irqEnQ;
  logic [DATA_W-1:0]     nextQ;
  logic [DATA_W-1:0]     curQ;
  logic [DATA_W-1:0]     rdQ;
  logic [NUM_STICKY-1:0] stickyQ;
  logic [NUM_STICKY-1:0] evt;
  logic [DATA_W-1:0]     ctrlWord;

  // completion events gated by the latched descriptor interrupt flag
  assign evt = {engErrMstAbort, engErrTgtAbort, engErrMcAbort, engErrParity,
                engEoc & irqEnQ, engEot & irqEnQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      appendQ <= 1'b0;
      irqEnQ  <= 1'b0;
      nextQ   <= '0;
      curQ    <= '0;
    end else begin
      appendQ <= strb.wrCtrl & busWrData[BIT_APPEND];
      if (strb.wrCtrl) enableQ <= busWrData[BIT_ENABLE];
      if (strb.wrNext) nextQ <= busWrData;
      if (engFetch) begin
        curQ   <= engFetchAddr;
        irqEnQ <= engFetchIrqEn;
      end
    end
  end

  for (genvar g = 0; g < NUM_STICKY; g++) begin : gSticky
    logic clrHit;
    assign clrHit = strb.wrStat & busWrData[STICKY_POS[g]];
    always_ff @(posedge clk) begin
      if (!rstN) stickyQ[g] <= 1'b0;
      else       stickyQ[g] <= evt[g] | (stickyQ[g] & ~clrHit);
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[BIT_BUSY] = engBusy;
    for (int k = 0; k < NUM_STICKY; k++) statusWord[STICKY_POS[k]] = stickyQ[k];
    ctrlWord = '0;
    ctrlWord[BIT_ENABLE] = enableQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdQ <= '0;
    else if (strb.rdStb) begin
      case (strb.rdSel)
        SEL_CTRL: rdQ <= ctrlWord;
        SEL_STAT: rdQ <= statusWord;
        SEL_CUR:  rdQ <= curQ;
        SEL_NEXT: rdQ <= nextQ;
        default:  rdQ <= '0;
      endcase
    end
  end

  assign busRdData    = rdQ;
  assign chanEnable   = enableQ;
  assign appendPulse  = appendQ;
  assign nextDescAddr = nextQ;
  assign curDescAddr  = curQ;
  assign irq          = |stickyQ;
endmodule

// File: rtl/xfer_chan_csr.sv
`timescale 1ns/1ps
module xfer_chan_csr
  import xfer_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              engBusy,
  input  logic              engFetch,
  input  logic [DATA_W-1:0] engFetchAddr,
  input  logic              engFetchIrqEn,
  input  logic              engEot,
  input  logic              engEoc,
  input  logic              engErrParity,
  input  logic              engErrMcAbort,
  input  logic              engErrTgtAbort,
  input  logic              engErrMstAbort,
  output logic              chanEnable,
  output logic              appendPulse,
  output logic [DATA_W-1:0] nextDescAddr,
  output logic              irq
);
  csrStrobeT         strb;
  logic [DATA_W-1:0] curDescAddr;
  logic [DATA_W-1:0] statusWord;

  xfer_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .strb(strb)
  );

  xfer_csr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .busRdData(busRdData), .engBusy(engBusy), .engFetch(engFetch),
    .engFetchAddr(engFetchAddr), .engFetchIrqEn(engFetchIrqEn),
    .engEot(engEot), .engEoc(engEoc), .engErrParity(engErrParity),
    .engErrMcAbort(engErrMcAbort), .engErrTgtAbort(engErrTgtAbort),
    .engErrMstAbort(engErrMstAbort), .chanEnable(chanEnable),
    .appendPulse(appendPulse), .nextDescAddr(nextDescAddr),
    .curDescAddr(curDescAddr), .statusWord(statusWord), .irq(irq)
  );
endmodule

// File: rtl/xfer_chan_csr_chk.sv
`timescale 1ns/1ps
module xfer_chan_csr_chk
  import xfer_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              engFetch,
  input logic              engEot,
  input logic              engEoc,
  input logic              engErrParity,
  input logic              engErrMcAbort,
  input logic              engErrTgtAbort,
  input logic              engErrMstAbort,
  input logic              chanEnable,
  input logic              appendPulse,
  input logic              irq,
  input logic [DATA_W-1:0] curDescAddr,
  input logic [DATA_W-1:0] statusWord
);
  logic ctrlWr, statWr, undefAddr, anyEvt;
  assign ctrlWr = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));
  assign statWr = busWrEn && (busAddr == ADDR_W'(OFS_STAT));
  assign undefAddr = (busAddr != ADDR_W'(OFS_CTRL)) && (busAddr != ADDR_W'(OFS_STAT)) &&
                     (busAddr != ADDR_W'(OFS_CUR)) && (busAddr != ADDR_W'(OFS_NEXT));
  assign anyEvt = engEot | engEoc | engErrParity | engErrMcAbort | engErrTgtAbort | engErrMstAbort;

  AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (chanEnable == $past(busWrData[BIT_ENABLE]))); // R2
  AST_APPEND_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    appendPulse |-> $past(ctrlWr && busWrData[BIT_APPEND])); // R3
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !engFetch |=> $stable(curDescAddr)); // R5
  AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    engErrParity |=> statusWord[9]); // R8
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && busWrData[9] && !engErrParity) |=> !statusWord[9]); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(anyEvt)); // R10
  AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && undefAddr) |=> (busRdData == '0)); // R11
endmodule

bind xfer_chan_csr xfer_chan_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .engFetch(engFetch),
  .engEot(engEot), .engEoc(engEoc), .engErrParity(engErrParity),
  .engErrMcAbort(engErrMcAbort), .engErrTgtAbort(engErrTgtAbort),
  .engErrMstAbort(engErrMstAbort), .chanEnable(chanEnable),
  .appendPulse(appendPulse), .irq(irq), .curDescAddr(curDescAddr),
  .statusWord(statusWord)
);

// File: tb/xfer_chan_csr_bench.sv
`timescale 1ns/1ps
module xfer_chan_csr_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn, busRdEn;
  logic [7:0]  busAddr;
  logic [31:0] busWrData, busRdData;
  logic        engBusy, engFetch, engFetchIrqEn;
  logic [31:0] engFetchAddr;
  logic        engEot, engEoc, engErrParity, engErrMcAbort, engErrTgtAbort, engErrMstAbort;
  logic        chanEnable, appendPulse, irq;
  logic [31:0] nextDescAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic        mEn, mIrqEn;
  logic [31:0] mNext, mCur, mRd;
  logic [5:0]  mSticky;
  logic        mAppend;
  int          stickyPos [6] = '{12, 11, 9, 5, 4, 3};

  always #10 clk = ~clk;

  xfer_chan_csr u_xfer_chan_csr (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .engBusy(engBusy),
    .engFetch(engFetch), .engFetchAddr(engFetchAddr), .engFetchIrqEn(engFetchIrqEn),
    .engEot(engEot), .engEoc(engEoc), .engErrParity(engErrParity),
    .engErrMcAbort(engErrMcAbort), .engErrTgtAbort(engErrTgtAbort),
    .engErrMstAbort(engErrMstAbort), .chanEnable(chanEnable),
    .appendPulse(appendPulse), .nextDescAddr(nextDescAddr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelStatus();
    logic [31:0] s = '0;
    s[13] = engBusy;
    for (int k = 0; k < 6; k++) s[stickyPos[k]] = mSticky[k];
    return s;
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00:   return {31'b0, mEn};
      8'h04:   return modelStatus();
      8'h08:   return mCur;
      8'h24:   return mNext;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [7:0] a);
    case (a)
      8'h00:   return "R2 R3 control read";
      8'h04:   return "R6 R7 R8 R9 status read";
      8'h08:   return "R5 current descriptor read";
      8'h24:   return "R4 next descriptor read";
      default: return "R11 undefined offset read";
    endcase
  endfunction

  task automatic clearDrive();
    busWrEn = 0; busRdEn = 0; busAddr = '0; busWrData = '0;
    engFetch = 0; engFetchAddr = '0; engFetchIrqEn = 0;
    engEot = 0; engEoc = 0; engErrParity = 0; engErrMcAbort = 0;
    engErrTgtAbort = 0; engErrMstAbort = 0;
  endtask

  // inputs are set at a falling edge; tick advances one cycle and checks
  task automatic tick();
    logic [5:0] ev;
    logic [7:0] lastAddr = busAddr;
    if (busRdEn) mRd = modelRead(busAddr);
    mAppend = busWrEn && busAddr == 8'h00 && busWrData[1];
    ev = {engErrMstAbort, engErrTgtAbort, engErrMcAbort, engErrParity,
          engEoc & mIrqEn, engEot & mIrqEn};
    for (int k = 0; k < 6; k++)
      mSticky[k] = ev[k] | (mSticky[k] & ~(busWrEn && busAddr == 8'h04 && busWrData[stickyPos[k]]));
    if (busWrEn && busAddr == 8'h00) mEn = busWrData[0];
    if (busWrEn && busAddr == 8'h24) mNext = busWrData;
    if (engFetch) begin mCur = engFetchAddr; mIrqEn = engFetchIrqEn; end
    @(posedge clk);
    @(negedge clk);
    check(readTag(lastAddr), busRdData, mRd);
    check("R2 chanEnable", {31'b0, chanEnable}, {31'b0, mEn});
    check("R3 appendPulse", {31'b0, appendPulse}, {31'b0, mAppend});
    check("R4 nextDescAddr", nextDescAddr, mNext);
    check("R10 irq", {31'b0, irq}, {31'b0, |mSticky});
    clearDrive();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1; busAddr = a; busWrData = d; tick();
  endtask

  task automatic rd(input logic [7:0] a);
    busRdEn = 1; busAddr = a; tick();
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrSet [8] = '{8'h00, 8'h04, 8'h08, 8'h24, 8'h0C, 8'h28, 8'h3C, 8'hFF};
    void'($urandom(32'd20240611));
    rstN = 0; engBusy = 0; clearDrive();
    mEn = 0; mIrqEn = 0; mNext = '0; mCur = '0; mRd = '0; mSticky = '0; mAppend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset chanEnable", {31'b0, chanEnable}, 32'h0);
    check("R1 reset appendPulse", {31'b0, appendPulse}, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    check("R1 reset nextDescAddr", nextDescAddr, 32'h0);
    check("R1 reset busRdData", busRdData, 32'h0);
    rstN = 1;
    rd(8'h04); rd(8'h08);                    // R1 registers read zero

    // R2 / R3 enable and append
    wr(8'h00, 32'h3);
    tick();                                  // R3 pulse drops after one cycle
    rd(8'h00);
    wr(8'h00, 32'h2);                        // append while disabling
    rd(8'h00);

    // R4 next descriptor
    wr(8'h24, 32'hDEAD_BEE0);
    rd(8'h24);

    // R5 current descriptor: writes ignored, fetch loads
    wr(8'h08, 32'h1234_5678);
    rd(8'h08);
    engFetch = 1; engFetchAddr = 32'h0000_A0C0; engFetchIrqEn = 1; tick();
    rd(8'h08);

    // R6 busy
    engBusy = 1; rd(8'h04);
    engBusy = 0; rd(8'h04);

    // R7 gated completion
    engEot = 1; tick();
    rd(8'h04);
    engFetch = 1; engFetchAddr = 32'h0000_B000; engFetchIrqEn = 0; tick();
    engEoc = 1; tick();                      // not recorded
    rd(8'h04);

    // R8 errors, R9 partial clear and priority
    engErrParity = 1; engErrMcAbort = 1; engErrTgtAbort = 1; engErrMstAbort = 1; tick();
    rd(8'h04);
    wr(8'h04, 32'h0000_0228);                // clear bits 9, 5, 3
    rd(8'h04);
    wr(8'h04, 32'h0);                        // zeros change nothing
    rd(8'h04);
    busWrEn = 1; busAddr = 8'h04; busWrData = 32'h0000_0010; engErrTgtAbort = 1; tick();
    rd(8'h04);
    wr(8'h04, 32'hFFFF_FFFF);                // R10 irq drops
    rd(8'h04);

    // R11 undefined offsets
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28); rd(8'h00); rd(8'h24);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 3);
      busAddr = addrSet[$urandom_range(0, 7)];
      busWrData = $urandom();
      if (op == 0) busWrEn = 1;
      else if (op == 1) busRdEn = 1;
      else if (op == 2) begin busWrEn = 1; busRdEn = 1; end
      engBusy = $urandom_range(0, 1);
      engFetch = ($urandom_range(0, 7) == 0);
      engFetchAddr = $urandom();
      engFetchIrqEn = $urandom_range(0, 1);
      engEot = ($urandom_range(0, 7) == 0);
      engEoc = ($urandom_range(0, 7) == 0);
      engErrParity = ($urandom_range(0, 15) == 0);
      engErrMcAbort = ($urandom_range(0, 15) == 0);
      engErrTgtAbort = ($urandom_range(0, 15) == 0);
      engErrMstAbort = ($urandom_range(0, 15) == 0);
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule